// File: doc/BRIEF.md
# Two-Wire Target Front End for a Sampling Converter

This block is the serial-bus target side of a small multi-channel converter. It watches oversampled copies of the bus clock and data lines, recognises its own 7-bit address, and pulls the data line low through an open-drain enable output. It never drives the line high. A write transfer carries one byte that becomes the converter setting word. This word holds four channel enables, a reference select, a filter bypass and two delay disables. The word is also exported so the converter can use it.

A read transfer starts a conversion as soon as the target acknowledges the address. The target then streams the result as byte pairs. The first byte of a pair holds two zero bits, the 2-bit channel number and the top four result bits. The second byte holds the remaining result bits, left-justified with zero fill. Each master acknowledge after the second byte requests a fresh conversion on the next enabled channel. A not-acknowledge ends the stream. The high-speed master code is never acknowledged. It raises a mode flag that only a STOP clears. Conversions are handed off through a request/done port.

Top module: `i2c_conv_target`

## Requirements
- R1: The target acknowledges (drives SDA low on the 9th clock) only an address byte whose upper 7 bits equal 0101000 or 0101001, as picked by the strap parameter. Any other address is not acknowledged, and SDA stays released until the next START or STOP.
- R2: After reset the setting word is 0xF0. An acknowledged write stores the first data byte into it. Bits 7..4 enable channels 3..0, bit 3 selects the external reference, bit 2 bypasses the filter, bit 1 disables the bit-trial delay and bit 0 disables the sample delay.
- R3: A second data byte in the same write is not acknowledged and leaves the setting word unchanged.
- R4: The falling SCL edge that ends the acknowledged read-address byte produces a one-cycle conversion request. Its channel is the first enabled channel after the previously converted one, in cyclic order 0,1,2,3. The channel before the first request is taken as 3.
- R5: The first byte of each read pair is {0, 0, channel[1:0], result[11:8]} and the second byte is result[7:0]. A result narrower than 12 bits is left-justified: 2 zero low bits for 10 bits, 4 for 8 bits.
- R6: A master ACK after the second byte requests another conversion on the next channel and starts a new pair. A master NACK requests nothing further and releases SDA.
- R7: The pair's contents are captured at the falling SCL edge that shifts out the third bit of the first byte. If the requested conversion has not completed by then, the last completed result and its channel are sent.
- R8: A first byte of the form 00001xxx is not acknowledged and sets the high-speed flag. The flag survives repeated STARTs and clears only on STOP.
- R9: A START at any point aborts the current transfer, releases SDA and begins a new address byte. A partially received data byte is discarded.
- R10: With reference select set (bit 3 = 1), channel 3 is excluded from the sequence even when its enable is set.
- R11: With no channel enabled, the request uses channel 0.
- R12: After reset, SDA is released, no conversion is requested and the high-speed flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 2 | Channel of the pending request |
| conv_done_i | input | 1 | Conversion complete strobe |
| conv_result_i | input | RES_W | Result, valid with conv_done_i |
| cfg_o | output | 8 | Current setting word |
| hs_mode_o | output | 1 | High-speed mode flag |

## Verification
The bench builds the block with the strap set to 1 and a 10-bit result. Sending the other strap's address therefore exercises the mismatch path, and every read pair must show the two zero padding bits. A bench-side converter with an adjustable latency lets the same read sequence show both the fresh-result and the stale-result capture. Channel masks with and without the reference bit reach the skip, wrap and empty-mask cases of the sequencer.

// File: rtl/i2c_conv_pkg.sv
`timescale 1ns/1ps
package i2c_conv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } tgt_state_e;

  localparam int unsigned CFG_W       = 8;
  localparam int unsigned NUM_CH      = 4;
  localparam int unsigned CH_W        = $clog2(NUM_CH);
  localparam int unsigned FRAME_RES_W = 12;
  localparam int unsigned WORD_W      = CH_W + FRAME_RES_W;
  localparam logic [CFG_W-1:0] CFG_RST   = 8'hF0;
  localparam logic [6:0]       ADDR_BASE = 7'b0101000;
  localparam logic [4:0]       HS_PREFIX = 5'b00001;
endpackage

// File: rtl/i2c_conv_line_sync.sv
`timescale 1ns/1ps
module i2c_conv_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr[0] <= scl_i;
      sda_sr[0] <= sda_i;
      for (int i = 1; i < int'(STAGES); i++) begin
        scl_sr[i] <= scl_sr[i-1];
        sda_sr[i] <= sda_sr[i-1];
      end
      scl_p <= scl_sr[STAGES-1];
      sda_p <= sda_sr[STAGES-1];
    end
  end

  assign scl_o      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA edges with SCL high in both samples
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_conv_seq.sv
`timescale 1ns/1ps
module i2c_conv_seq import i2c_conv_pkg::*; #(
  parameter int unsigned RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              req_i,
  input  logic              done_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_chan_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned PAD = FRAME_RES_W - RES_W;

  logic [NUM_CH-1:0] en_mask;
  logic [CH_W-1:0]   last_q, nxt_ch, held_ch_q;
  logic [RES_W-1:0]  held_res_q;
  logic              pend_q;

  assign en_mask = cfg_i[7:4] & ~{cfg_i[3], {(NUM_CH-1){1'b0}}};

  // first enabled channel after last_q, cyclic; channel 0 when none
  always_comb begin
    nxt_ch = '0;
    for (int i = NUM_CH; i >= 1; i--) begin
      if (en_mask[CH_W'(int'(last_q) + i)]) nxt_ch = CH_W'(int'(last_q) + i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_req_o  <= 1'b0;
      conv_chan_o <= '0;
      last_q      <= CH_W'(NUM_CH - 1);
      pend_q      <= 1'b0;
      held_ch_q   <= '0;
      held_res_q  <= '0;
    end else begin
      conv_req_o <= req_i;
      if (done_i && pend_q) begin
        held_res_q <= result_i;
        held_ch_q  <= conv_chan_o;
        pend_q     <= 1'b0;
      end
      if (req_i) begin
        conv_chan_o <= nxt_ch;
        last_q      <= nxt_ch;
        pend_q      <= 1'b1;
      end
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign word_o = {held_ch_q, held_res_q, {PAD{1'b0}}};
    end else begin : g_nopad
      assign word_o = {held_ch_q, held_res_q};
    end
  endgenerate

  // R10 R11
  chan_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> ((en_mask == '0) && (conv_chan_o == '0)) || en_mask[conv_chan_o]);
endmodule

// File: rtl/i2c_conv_target.sv
`timescale 1ns/1ps
module i2c_conv_target import i2c_conv_pkg::*; #(
  parameter logic        ADDR_SEL    = 1'b0,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             conv_req_o,
  output logic [1:0]       conv_chan_o,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  output logic [7:0]       cfg_o,
  output logic             hs_mode_o
);
  localparam logic [6:0] OWN_ADDR = ADDR_BASE | {6'd0, ADDR_SEL};

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic              is_read_q, byte1_q, mack_q, sda_oe_q, hs_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [WORD_W-1:0] tx_word_q, held_word, src_word;
  logic [2:0]        bit_pos;
  logic              nxt_bit, req_evt;

  i2c_conv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign req_evt = scl_fall && ((state_q == ST_ADDR_ACK && is_read_q) ||
                                (state_q == ST_RD_ACK && mack_q && byte1_q));

  i2c_conv_seq #(.RES_W(RES_W)) u_seq (
    .clk_i, .rst_ni, .cfg_i(cfg_q), .req_i(req_evt),
    .done_i(conv_done_i), .result_i(conv_result_i),
    .conv_req_o, .conv_chan_o, .word_o(held_word)
  );

  // next bit of a read byte; first byte takes a fresh snapshot at its third bit
  always_comb begin
    src_word = (!byte1_q && cnt_q == 4'd1) ? held_word : tx_word_q;
    bit_pos  = 3'd6 - cnt_q[2:0];
    if (byte1_q)              nxt_bit = tx_word_q[bit_pos];
    else if (bit_pos >= 3'd6) nxt_bit = 1'b0;
    else                      nxt_bit = src_word[{1'b1, bit_pos}];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      is_read_q <= 1'b0;
      byte1_q   <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      hs_q      <= 1'b0;
      cfg_q     <= CFG_RST;
      tx_word_q <= '0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
      hs_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == OWN_ADDR) begin
              sda_oe_q  <= 1'b1;
              is_read_q <= sh_q[0];
              state_q   <= ST_ADDR_ACK;
            end else begin
              if (sh_q[7:3] == HS_PREFIX) hs_q <= 1'b1;
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (is_read_q) begin
            byte1_q  <= 1'b0;
            sda_oe_q <= 1'b1;
            state_q  <= ST_RD;
          end else begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_WR;
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cfg_q    <= sh_q;
            sda_oe_q <= 1'b1;
            state_q  <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: if (scl_fall) begin
          sda_oe_q <= 1'b0;
          state_q  <= ST_SKIP;
        end
        ST_RD: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            sda_oe_q <= 1'b0;
            mack_q   <= 1'b0;
            state_q  <= ST_RD_ACK;
          end else begin
            cnt_q    <= cnt_q + 4'd1;
            sda_oe_q <= ~nxt_bit;
            if (!byte1_q && cnt_q == 4'd1) tx_word_q <= held_word;
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          else if (scl_fall) begin
            if (mack_q) begin
              cnt_q    <= '0;
              byte1_q  <= ~byte1_q;
              sda_oe_q <= byte1_q ? 1'b1 : ~tx_word_q[7];
              state_q  <= ST_RD;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign cfg_o     = cfg_q;
  assign hs_mode_o = hs_q;

  // R1
  ack_drive_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
  // R1
  skip_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_o);
  // R2
  cfg_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> $past(state_q) == ST_WR);
  // R8
  hs_exit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_mode_o) |-> $past(stop_det));
  // R4
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
endmodule

// File: tb/i2c_conv_target_tb.sv
`timescale 1ns/1ps
module i2c_conv_target_tb_top;
  localparam int RES_W = 10;
  localparam int H     = 10;
  localparam logic [6:0] OWN = 7'b0101001;
  localparam logic [6:0] OTHER = 7'b0101000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, conv_req, conv_done;
  logic [1:0] conv_chan;
  logic [RES_W-1:0] conv_res;
  logic [7:0] cfg;
  logic hs;

  int n_chk = 0, n_bad = 0, nreq = 0, lat = 4, busy_cnt = 0, mlast = 3, cyc = 0;
  int req_ch[$];
  int req_val[$];
  bit busy = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_conv_target #(.ADDR_SEL(1'b1), .RES_W(RES_W), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_done_i(conv_done),
    .conv_result_i(conv_res), .cfg_o(cfg), .hs_mode_o(hs)
  );

  // behavioural converter
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (busy) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt <= 0) begin
        busy = 0;
        conv_done <= 1'b1;
        conv_res  <= RES_W'(req_val[$]);
      end
    end
    if (conv_req === 1'b1) begin
      req_ch.push_back(int'(conv_chan));
      req_val.push_back(((nreq + 1) * 53 + 17) & 10'h3FF);
      nreq = nreq + 1;
      busy = 1;
      busy_cnt = lat;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    if (scl == 1'b0) begin sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); end
    sda_m = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = v[i]; wt(H); scl = 1'b1; wt(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    send_bits(v, 8);
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H/2);
    ack = !sda_line; wt(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H); scl = 1'b1; wt(H/2); v[i] = sda_line; wt(H/2); scl = 1'b0;
    end
    sda_m = !ack; wt(H); scl = 1'b1; wt(H); scl = 1'b0; sda_m = 1'b1;
  endtask

  function automatic int model_next(input logic [7:0] c);
    logic [3:0] en = c[7:4];
    if (c[3]) en[3] = 1'b0;
    for (int i = 1; i <= 4; i++) if (en[(mlast + i) % 4]) return (mlast + i) % 4;
    return 0;
  endfunction

  function automatic logic [15:0] pair_of(input int ch, input int val);
    logic [11:0] w = 12'(val) << 2;
    return {2'b00, 2'(ch), w};
  endfunction

  task automatic write_cfg(input logic [7:0] v, input string tag);
    bit a;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    chk(a, {tag, " addr ack"}, a, 1);
    send_byte(v, a);
    chk(a, {tag, " data ack"}, a, 1);
    bus_stop();
    chk(cfg == v, {tag, " cfg"}, cfg, v);
  endtask

  // one read pair; expected from request index idx
  task automatic read_pair(input int idx, input bit mack, input string tag);
    logic [7:0] b0, b1;
    logic [15:0] e;
    recv_byte(b0, 1'b1);
    recv_byte(b1, mack);
    e = pair_of(req_ch[idx], req_val[idx]);
    chk({b0, b1} == e, tag, {b0, b1}, e);
  endtask

  initial begin
    bit a;
    int exp_ch, n0;
    conv_done = 1'b0; conv_res = '0;
    wt(5); rst_n = 1'b1; wt(5);

    // R12 / R2 reset state
    chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    chk(conv_req == 1'b0, "R12 no request", conv_req, 0);
    chk(hs == 1'b0, "R12 hs low", hs, 0);
    chk(cfg == 8'hF0, "R2 cfg reset", cfg, 8'hF0);

    // R1 other strap address ignored
    bus_start();
    send_byte({OTHER, 1'b1}, a);
    chk(!a, "R1 foreign addr nack", a, 0);
    wt(3*H);
    chk(nreq == 0 && sda_oe == 1'b0, "R1 bus untouched", nreq, 0);
    bus_stop();

    // R2 write, channels 0 and 1
    write_cfg(8'h30, "R2");

    // R3 extra data byte
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h55, a);
    send_byte(8'hAA, a);
    chk(!a, "R3 extra byte nack", a, 0);
    bus_stop();
    chk(cfg == 8'h55, "R3 cfg keeps first byte", cfg, 8'h55);
    write_cfg(8'h30, "R2 restore");

    // R4 R5 R6 read with fast converter
    bus_start();
    send_byte({OWN, 1'b1}, a);
    chk(a, "R1 own addr ack", a, 1);
    wt(4);
    exp_ch = model_next(8'h30); mlast = exp_ch;
    chk(nreq == 1 && req_ch[0] == exp_ch, "R4 first request channel", req_ch[0], exp_ch);
    read_pair(0, 1'b1, "R5 pair 0");
    wt(4);
    exp_ch = model_next(8'h30); mlast = exp_ch;
    chk(nreq == 2 && req_ch[1] == exp_ch, "R6 ack requests next channel", req_ch[1], exp_ch);
    read_pair(1, 1'b0, "R5 pair 1");
    wt(4*H);
    chk(nreq == 2, "R6 nack no request", nreq, 2);
    chk(sda_oe == 1'b0, "R6 nack releases", sda_oe, 0);
    bus_stop();

    // R7 slow converter: previous result is sent
    lat = 400;
    bus_start();
    send_byte({OWN, 1'b1}, a);
    wt(4);
    exp_ch = model_next(8'h30); mlast = exp_ch;
    chk(nreq == 3 && req_ch[2] == exp_ch, "R4 wrap to channel 0", req_ch[2], exp_ch);
    read_pair(1, 1'b0, "R7 stale pair");
    bus_stop();
    wt(450);
    lat = 4;

    // R10 reference select drops channel 3; R11 empty mask
    write_cfg(8'h88, "R10 cfg");
    bus_start(); send_byte({OWN, 1'b1}, a); wt(4);
    exp_ch = model_next(8'h88); mlast = exp_ch;
    chk(req_ch[nreq-1] == exp_ch && exp_ch == 0, "R11 empty mask -> ch0", req_ch[nreq-1], 0);
    read_pair(nreq-1, 1'b0, "R5 ch0 pair");
    bus_stop();
    write_cfg(8'hC8, "R10 cfg2");
    bus_start(); send_byte({OWN, 1'b1}, a); wt(4);
    exp_ch = model_next(8'hC8); mlast = exp_ch;
    chk(req_ch[nreq-1] == 2, "R10 ch3 excluded", req_ch[nreq-1], 2);
    read_pair(nreq-1, 1'b1, "R5 ch2 pair");
    wt(4);
    exp_ch = model_next(8'hC8); mlast = exp_ch;
    chk(req_ch[nreq-1] == 2, "R10 repeat ch2", req_ch[nreq-1], 2);
    read_pair(nreq-1, 1'b0, "R5 ch2 pair b");
    bus_stop();

    // R8 master code
    bus_start();
    send_byte(8'h0B, a);
    chk(!a, "R8 master code nack", a, 0);
    chk(hs == 1'b1, "R8 hs set", hs, 1);
    bus_start();
    send_byte({OWN, 1'b1}, a);
    chk(a && hs == 1'b1, "R8 hs kept over restart", hs, 1);
    wt(4);
    exp_ch = model_next(8'hC8); mlast = exp_ch;
    read_pair(nreq-1, 1'b0, "R5 hs pair");
    bus_stop();
    wt(4);
    chk(hs == 1'b0, "R8 stop clears hs", hs, 0);

    // R9 start inside a data byte
    n0 = nreq;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_bits(8'h00, 4);
    bus_start();
    chk(cfg == 8'hC8, "R9 partial byte discarded", cfg, 8'hC8);
    send_byte({OWN, 1'b0}, a);
    chk(a, "R9 new address ack", a, 1);
    send_byte(8'h50, a);
    bus_stop();
    chk(cfg == 8'h50 && nreq == n0, "R9 cfg after abort", cfg, 8'h50);

    wt(20);
    summary();
  end
endmodule